// File: doc/BRIEF.md
# System Controller Register Bank

This block is the register front end of a small system controller. It sits on a simple word-wide bus with separate read and write strobes and a byte address. The bank holds the GPIO registers, the configuration words of two timers, a read-only reconfiguration status word, a capabilities word and a system identification word. The timer counting engines sit elsewhere. They take their control, compare and count words from this bank's outputs.

Two writes have side effects at the block's edge. Writing the shutdown command code into the reconfiguration word raises a one-cycle shutdown request. Any write to the identification word raises a one-cycle system reset request and leaves the identification value as it was. The GPIO input word follows the external pins through a two-stage synchronizer. At reset it is loaded from a strap parameter. A one-cycle interrupt pulse is raised when an enabled input bit changes.

Top module: `sysctl_regbank`

## Requirements
- R1: After reset the words read as follows: word 0 reads the strap value (default 0x00000001), word 13 reads 0x00000001 (ready), word 14 reads the capabilities parameter (default 0), word 15 reads 0x10014D31, and every other word reads 0. The outputs gpio_out, gpio_irq_en, gpio_irq, shutdown_req and sysrst_req are 0.
- R2: The word index is byte address bits [5:2], and address bits [1:0] are ignored. Any address at or above 0x40 is unmapped.
- R3: The read/write words store a written value, and each one drives its output port from the next cycle on. These words are word 1 (GPIO out), word 2 (interrupt enable), words 4/5/6 (timer 0 control/compare/count) and words 8/9/10 (timer 1 control/compare/count).
- R4: Writes to word 0, word 13 and word 14 do not change what those words read back.
- R5: Reserved words 3, 7, 11 and 12, and unmapped addresses, read as 0. Writes to them change no register.
- R6: A write to word 13 whose data bits [15:0] equal 0x000E raises shutdown_req for exactly the one cycle after the write, whatever bits [31:16] hold. Other data values raise nothing.
- R7: Any write to word 15 raises sysrst_req for exactly the one cycle after the write, and word 15 still reads 0x10014D31 afterwards.
- R8: After reset, word 0 follows the gpio_pins inputs through two synchronizer stages and one capture register.
- R9: gpio_irq pulses high for one cycle when a captured input bit whose enable bit is 1 changes. Changes on bits whose enable is 0 raise nothing.
- R10: bus_rdata takes the addressed word one cycle after bus_rd_en is sampled high, and holds its value while bus_rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe |
| bus_rd_en | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| gpio_pins | input | GPIO_W | External GPIO inputs (asynchronous) |
| gpio_out | output | GPIO_W | GPIO output word |
| gpio_irq_en | output | GPIO_W | GPIO interrupt enable mask |
| gpio_irq | output | 1 | GPIO change interrupt pulse |
| tmr_ctrl | output | NUM_TMR x 32 | Timer control words |
| tmr_compare | output | NUM_TMR x 32 | Timer compare words |
| tmr_count | output | NUM_TMR x 32 | Timer count load words |
| shutdown_req | output | 1 | Shutdown request pulse |
| sysrst_req | output | 1 | System reset request pulse |

## Verification
A corrupted storage word shows at its output port on the cycle after the write, and in bus_rdata one cycle after a read of that word. A decode slip appears the same way: it aliases one word onto another, so a read after a write reveals the wrong neighbour. A synchronizer or capture fault shifts the arrival of the interrupt pulse away from the third edge after a pin change. It can also make the pulse last two cycles or vanish. A wrong comparison on a side-effect write shows as a missing, extra or stretched request pulse in the cycle right after the write.

// File: rtl/sysctl_pkg.sv
// Shared constants and word indices for the system controller register bank.
// Assumes a 32-bit data path and a 16-word map.
package sysctl_pkg;
    localparam int DATA_W     = 32;
    localparam int NUM_TMR    = 2;
    localparam int WORD_LSB   = 2;
    localparam int WORD_IDX_W = 4;
    localparam int SLOT_W     = 2;
    localparam int MAP_TOP    = WORD_LSB + WORD_IDX_W;

    typedef enum logic [WORD_IDX_W-1:0] {
        W_GPIO_IN  = 4'd0,
        W_GPIO_OUT = 4'd1,
        W_GPIO_IEN = 4'd2,
        W_RCFG     = 4'd13,
        W_CAPS     = 4'd14,
        W_SYSID    = 4'd15
    } word_e;

    typedef enum logic [SLOT_W-1:0] {
        T_CTRL = 2'd0,
        T_CMP  = 2'd1,
        T_CNT  = 2'd2
    } tslot_e;

    localparam logic [15:0]       SHUTDOWN_CODE = 16'h000E;
    localparam logic [DATA_W-1:0] RCFG_READY    = 32'h0000_0001;
endpackage

// File: rtl/sysctl_decode.sv
// Address decoder: turns a byte address and write strobe into per-register
// write enables and side-effect hits. Purely combinational.
// Assumes ADDR_W >= 6. Addresses at or above 0x40 are unmapped.
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [15:0]           wcode,
    output logic                  in_map,
    output logic [WORD_IDX_W-1:0] word,
    output logic                  wr_gpio_out,
    output logic                  wr_gpio_ien,
    output logic [NUM_TMR-1:0]    wr_tctrl,
    output logic [NUM_TMR-1:0]    wr_tcmp,
    output logic [NUM_TMR-1:0]    wr_tcnt,
    output logic                  hit_shutdown,
    output logic                  hit_sysrst
);
    logic wr_ok;

    // Word index, map range and the fixed-word write enables
    always_comb begin
        word         = addr[WORD_LSB +: WORD_IDX_W];
        in_map       = (addr >> MAP_TOP) == '0;
        wr_ok        = wr_en && in_map;
        wr_gpio_out  = wr_ok && (word == W_GPIO_OUT);
        wr_gpio_ien  = wr_ok && (word == W_GPIO_IEN);
        hit_shutdown = wr_ok && (word == W_RCFG) && (wcode == SHUTDOWN_CODE);
        hit_sysrst   = wr_ok && (word == W_SYSID);
    end

    // Timer group t occupies word group t+1; slot is the low index bits
    for (genvar t = 0; t < NUM_TMR; t++) begin : g_tdec
        logic grp_hit;
        assign grp_hit     = wr_ok && (word[WORD_IDX_W-1:SLOT_W] == SLOT_W'(t + 1));
        assign wr_tctrl[t] = grp_hit && (word[SLOT_W-1:0] == T_CTRL);
        assign wr_tcmp[t]  = grp_hit && (word[SLOT_W-1:0] == T_CMP);
        assign wr_tcnt[t]  = grp_hit && (word[SLOT_W-1:0] == T_CNT);
    end
endmodule

// File: rtl/sysctl_gpio.sv
// GPIO registers: input synchronizer and capture, output word, interrupt
// enable and change-detect interrupt. The pins are asynchronous. The
// synchronizer and capture reset to the strap value, so no change is
// reported when reset is released.
module sysctl_gpio #(
    parameter int                GPIO_W = 32,
    parameter logic [GPIO_W-1:0] STRAP  = GPIO_W'(1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GPIO_W-1:0] pins,
    input  logic              wr_out,
    input  logic              wr_ien,
    input  logic [GPIO_W-1:0] wdata,
    output logic [GPIO_W-1:0] in_q,
    output logic [GPIO_W-1:0] out_q,
    output logic [GPIO_W-1:0] ien_q,
    output logic              irq
);
    logic [GPIO_W-1:0] sync1, sync2;

    // Two-stage synchronizer followed by the capture register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= STRAP;
            sync2 <= STRAP;
            in_q  <= STRAP;
        end else begin
            sync1 <= pins;
            sync2 <= sync1;
            in_q  <= sync2;
        end
    end

    // Software-written output and enable words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
            ien_q <= '0;
        end else begin
            if (wr_out) out_q <= wdata;
            if (wr_ien) ien_q <= wdata;
        end
    end

    // One-cycle pulse when an enabled bit is about to change in the capture
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |((sync2 ^ in_q) & ien_q);
    end
endmodule

// File: rtl/sysctl_tmr_regs.sv
// Configuration words of one timer: control, compare and count load.
// Plain storage that the external timer engine reads.
module sysctl_tmr_regs
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_cmp,
    input  logic              wr_cnt,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] cmp_q,
    output logic [DATA_W-1:0] cnt_q
);
    // Store each word on its own write enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            cmp_q  <= '0;
            cnt_q  <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= wdata;
            if (wr_cmp)  cmp_q  <= wdata;
            if (wr_cnt)  cnt_q  <= wdata;
        end
    end
endmodule

// File: rtl/sysctl_regbank.sv
// System controller register bank: 16 words on a strobe bus with registered
// read data. Side-effect writes raise one-cycle shutdown and system reset
// requests. Accesses are assumed to be full words; byte lanes are not used.
module sysctl_regbank
    import sysctl_pkg::*;
#(
    parameter int                ADDR_W = 8,
    parameter int                GPIO_W = 32,
    parameter logic [GPIO_W-1:0] STRAP  = GPIO_W'(1),
    parameter logic [31:0]       CAPS   = 32'h0000_0000,
    parameter logic [31:0]       SYS_ID = 32'h1001_4D31
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            bus_wr_en,
    input  logic                            bus_rd_en,
    input  logic [ADDR_W-1:0]               bus_addr,
    input  logic [31:0]                     bus_wdata,
    output logic [31:0]                     bus_rdata,
    input  logic [GPIO_W-1:0]               gpio_pins,
    output logic [GPIO_W-1:0]               gpio_out,
    output logic [GPIO_W-1:0]               gpio_irq_en,
    output logic                            gpio_irq,
    output logic [sysctl_pkg::NUM_TMR-1:0][31:0] tmr_ctrl,
    output logic [sysctl_pkg::NUM_TMR-1:0][31:0] tmr_compare,
    output logic [sysctl_pkg::NUM_TMR-1:0][31:0] tmr_count,
    output logic                            shutdown_req,
    output logic                            sysrst_req
);
    logic                  in_map;
    logic [WORD_IDX_W-1:0] word;
    logic                  wr_gpio_out, wr_gpio_ien;
    logic [NUM_TMR-1:0]    wr_tctrl, wr_tcmp, wr_tcnt;
    logic                  hit_shutdown, hit_sysrst;
    logic [GPIO_W-1:0]     gpio_in_q;
    logic [DATA_W-1:0]     rd_mux;

    sysctl_decode #(.ADDR_W(ADDR_W)) u_dec (
        .wr_en        (bus_wr_en),
        .addr         (bus_addr),
        .wcode        (bus_wdata[15:0]),
        .in_map       (in_map),
        .word         (word),
        .wr_gpio_out  (wr_gpio_out),
        .wr_gpio_ien  (wr_gpio_ien),
        .wr_tctrl     (wr_tctrl),
        .wr_tcmp      (wr_tcmp),
        .wr_tcnt      (wr_tcnt),
        .hit_shutdown (hit_shutdown),
        .hit_sysrst   (hit_sysrst)
    );

    sysctl_gpio #(.GPIO_W(GPIO_W), .STRAP(STRAP)) u_gpio (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins   (gpio_pins),
        .wr_out (wr_gpio_out),
        .wr_ien (wr_gpio_ien),
        .wdata  (bus_wdata[GPIO_W-1:0]),
        .in_q   (gpio_in_q),
        .out_q  (gpio_out),
        .ien_q  (gpio_irq_en),
        .irq    (gpio_irq)
    );

    for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
        sysctl_tmr_regs u_tregs (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_ctrl (wr_tctrl[t]),
            .wr_cmp  (wr_tcmp[t]),
            .wr_cnt  (wr_tcnt[t]),
            .wdata   (bus_wdata),
            .ctrl_q  (tmr_ctrl[t]),
            .cmp_q   (tmr_compare[t]),
            .cnt_q   (tmr_count[t])
        );
    end

    // Read multiplexer; reserved and unmapped words give zero
    always_comb begin
        rd_mux = '0;
        if (in_map) begin
            case (word)
                W_GPIO_IN:  rd_mux = DATA_W'(gpio_in_q);
                W_GPIO_OUT: rd_mux = DATA_W'(gpio_out);
                W_GPIO_IEN: rd_mux = DATA_W'(gpio_irq_en);
                W_RCFG:     rd_mux = RCFG_READY;
                W_CAPS:     rd_mux = CAPS;
                W_SYSID:    rd_mux = SYS_ID;
                default: begin
                    for (int t = 0; t < NUM_TMR; t++) begin
                        if (word[WORD_IDX_W-1:SLOT_W] == SLOT_W'(t + 1)) begin
                            case (word[SLOT_W-1:0])
                                T_CTRL:  rd_mux = tmr_ctrl[t];
                                T_CMP:   rd_mux = tmr_compare[t];
                                T_CNT:   rd_mux = tmr_count[t];
                                default: rd_mux = '0;
                            endcase
                        end
                    end
                end
            endcase
        end
    end

    // Registered read data, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n)         bus_rdata <= '0;
        else if (bus_rd_en) bus_rdata <= rd_mux;
    end

    // One-cycle request pulses from side-effect writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shutdown_req <= 1'b0;
            sysrst_req   <= 1'b0;
        end else begin
            shutdown_req <= hit_shutdown;
            sysrst_req   <= hit_sysrst;
        end
    end
endmodule

// File: rtl/sysctl_regbank_chk.sv
// Port-level checker for sysctl_regbank, bound to every instance.
module sysctl_regbank_chk #(
    parameter int                ADDR_W = 8,
    parameter int                GPIO_W = 32,
    parameter logic [31:0]       CAPS   = 32'h0000_0000,
    parameter logic [31:0]       SYS_ID = 32'h1001_4D31
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr_en,
    input logic              bus_rd_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [GPIO_W-1:0] gpio_out,
    input logic [GPIO_W-1:0] gpio_irq_en,
    input logic              gpio_irq,
    input logic              shutdown_req,
    input logic              sysrst_req
);
    logic [3:0] w;
    logic       mapped;
    assign w      = bus_addr[5:2];
    assign mapped = (bus_addr >> 6) == '0;

    assert_shutdown_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |-> $past(bus_wr_en && mapped && w == 4'd13 && bus_wdata[15:0] == 16'h000E));

    assert_sysrst_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sysrst_req |-> $past(bus_wr_en && mapped && w == 4'd15));

    assert_id_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && mapped && w == 4'd15) |=> bus_rdata == SYS_ID);

    assert_caps_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && mapped && w == 4'd14) |=> bus_rdata == CAPS);

    assert_rsvd_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && (!mapped || w == 4'd3 || w == 4'd7 || w == 4'd11 || w == 4'd12))
        |=> bus_rdata == 32'h0);

    assert_out_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && mapped && w == 4'd1) |=> gpio_out == $past(bus_wdata[GPIO_W-1:0]));

    assert_irq_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        gpio_irq |-> $past(|gpio_irq_en));

    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_en |=> $stable(bus_rdata));
endmodule

bind sysctl_regbank sysctl_regbank_chk #(
    .ADDR_W(ADDR_W), .GPIO_W(GPIO_W), .CAPS(CAPS), .SYS_ID(SYS_ID)
) u_chk (.*);

// File: tb/sysctl_regbank_tb.sv
// Self-checking bench: table-driven write/readback, then directed tests.
module sysctl_regbank_tb;
    localparam int ADDR_W = 8;
    localparam int GPIO_W = 32;
    localparam int NT     = 2;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    bus_wr_en = 1'b0, bus_rd_en = 1'b0;
    logic [ADDR_W-1:0]       bus_addr = '0;
    logic [31:0]             bus_wdata = '0;
    logic [31:0]             bus_rdata;
    logic [GPIO_W-1:0]       gpio_pins = 32'h1;
    logic [GPIO_W-1:0]       gpio_out, gpio_irq_en;
    logic                    gpio_irq;
    logic [NT-1:0][31:0]     tmr_ctrl, tmr_compare, tmr_count;
    logic                    shutdown_req, sysrst_req;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    sysctl_regbank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .gpio_pins(gpio_pins), .gpio_out(gpio_out), .gpio_irq_en(gpio_irq_en),
        .gpio_irq(gpio_irq), .tmr_ctrl(tmr_ctrl), .tmr_compare(tmr_compare),
        .tmr_count(tmr_count), .shutdown_req(shutdown_req), .sysrst_req(sysrst_req)
    );

    // {req, byte addr, write data, expected readback}
    localparam logic [75:0] VEC [16] = '{
        {4'd3, 8'h04, 32'hA5A5_0F0F, 32'hA5A5_0F0F},  // R3 gpio out
        {4'd3, 8'h08, 32'h0000_00FF, 32'h0000_00FF},  // R3 irq enable
        {4'd3, 8'h10, 32'h0000_0003, 32'h0000_0003},  // R3 timer0 ctrl
        {4'd3, 8'h14, 32'hDEAD_BEEF, 32'hDEAD_BEEF},  // R3 timer0 compare
        {4'd3, 8'h18, 32'h1234_5678, 32'h1234_5678},  // R3 timer0 count
        {4'd3, 8'h20, 32'h0000_0001, 32'h0000_0001},  // R3 timer1 ctrl
        {4'd3, 8'h24, 32'hCAFE_F00D, 32'hCAFE_F00D},  // R3 timer1 compare
        {4'd3, 8'h28, 32'h0BAD_F00D, 32'h0BAD_F00D},  // R3 timer1 count
        {4'd4, 8'h00, 32'hFFFF_FFFF, 32'h0000_0001},  // R4 gpio in
        {4'd4, 8'h38, 32'hFFFF_FFFF, 32'h0000_0000},  // R4 caps
        {4'd4, 8'h34, 32'h0000_1234, 32'h0000_0001},  // R4 reconfig status
        {4'd5, 8'h0C, 32'hFFFF_FFFF, 32'h0000_0000},  // R5 reserved
        {4'd5, 8'h1C, 32'hFFFF_FFFF, 32'h0000_0000},  // R5 reserved
        {4'd5, 8'h2C, 32'hFFFF_FFFF, 32'h0000_0000},  // R5 reserved
        {4'd5, 8'h30, 32'hFFFF_FFFF, 32'h0000_0000},  // R5 reserved
        {4'd2, 8'h07, 32'h1111_2222, 32'h1111_2222}   // R2 low bits ignored
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd_en = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd_en = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] reset_value(input int w);
        case (w)
            0:       return 32'h0000_0001;
            13:      return 32'h0000_0001;
            15:      return 32'h1001_4D31;
            default: return 32'h0;
        endcase
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [31:0] rd;
        int pulses;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values of every word and of the outputs
        check("R1 gpio_out", gpio_out, 32'h0);
        check("R1 irq_en", gpio_irq_en, 32'h0);
        check("R1 pulses", {29'h0, gpio_irq, shutdown_req, sysrst_req}, 32'h0);
        for (int w = 0; w < 16; w++) begin
            do_read(8'(w * 4), rd);
            check($sformatf("R1 word %0d", w), rd, reset_value(w));
        end

        // Table walk: write then read back (R2 R3 R4 R5)
        for (int i = 0; i < 16; i++) begin
            do_write(VEC[i][71:64], VEC[i][63:32]);
            do_read(VEC[i][71:64], rd);
            check($sformatf("R%0d addr %h", VEC[i][75:72], VEC[i][71:64]), rd, VEC[i][31:0]);
        end

        // R3: storage reaches the output ports
        check("R3 gpio_out port", gpio_out, 32'h1111_2222);
        check("R3 irq_en port", gpio_irq_en, 32'h0000_00FF);
        check("R3 tmr0 compare port", tmr_compare[0], 32'hDEAD_BEEF);
        check("R3 tmr1 count port", tmr_count[1], 32'h0BAD_F00D);
        check("R3 tmr1 ctrl port", tmr_ctrl[1], 32'h0000_0001);

        // R5: unmapped address is ignored and reads zero (0x44 would alias word 1)
        do_write(8'h44, 32'h0);
        check("R5 unmapped write", gpio_out, 32'h1111_2222);
        do_read(8'h44, rd);
        check("R5 unmapped read", rd, 32'h0);

        // R10: read data holds while no read, even across a write
        do_read(8'h14, rd);
        do_write(8'h14, 32'h5555_AAAA);
        repeat (2) @(negedge clk);
        check("R10 hold", bus_rdata, 32'hDEAD_BEEF);
        do_read(8'h14, rd);
        check("R10 new read", rd, 32'h5555_AAAA);

        // R6: shutdown code with upper bits set
        do_write(8'h34, 32'hFFFF_000E);
        check("R6 pulse high", {31'h0, shutdown_req}, 32'h1);
        @(negedge clk);
        check("R6 pulse low", {31'h0, shutdown_req}, 32'h0);
        do_write(8'h34, 32'h0000_000F);
        check("R6 other code", {31'h0, shutdown_req}, 32'h0);

        // R7: write to the id word
        do_write(8'h3C, 32'h0);
        check("R7 pulse high", {31'h0, sysrst_req}, 32'h1);
        @(negedge clk);
        check("R7 pulse low", {31'h0, sysrst_req}, 32'h0);
        do_read(8'h3C, rd);
        check("R7 id kept", rd, 32'h1001_4D31);

        // R9: change on a masked bit raises no interrupt
        @(negedge clk);
        gpio_pins = 32'h0000_0101;
        pulses = 0;
        repeat (5) begin
            @(negedge clk);
            if (gpio_irq) pulses++;
        end
        check("R9 masked", 32'(pulses), 32'h0);

        // R8: input word follows the pins
        do_read(8'h00, rd);
        check("R8 gpio in", rd, 32'h0000_0101);

        // R9: enabled bit change, pulse on the third edge only
        gpio_pins = 32'h0000_0109;
        @(negedge clk);
        @(negedge clk);
        check("R9 before", {31'h0, gpio_irq}, 32'h0);
        @(negedge clk);
        check("R9 pulse", {31'h0, gpio_irq}, 32'h1);
        @(negedge clk);
        check("R9 after", {31'h0, gpio_irq}, 32'h0);
        do_read(8'h00, rd);
        check("R8 gpio in second", rd, 32'h0000_0109);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule